// File: doc/BRIEF.md
# Regulator Enable and Soft-Start Sequencer

This block brings a switching regulator up and takes it down in a fixed order. When the enable input goes high, and the supply is above its lockout level and the die is not overheated, the sequencer first powers the internal reference. After a fixed wake-up delay it starts a digital soft-start ramp. The ramp is a reference code that climbs one step at a time from zero to full scale. Both the voltage loop and the current loop follow this code, so the output rises in a controlled way. Once the code reaches full scale it holds there and a startup-done flag is raised.

Dropping enable, or a lockout event, stops switching in the same cycle. It also opens the output discharge path and clears the ramp code. A thermal trip stops the regulator completely, but does not discharge the output. The regulator stays off until the sensor reports the cool threshold, and then restarts through a complete wake-up and ramp. While the block is running it also issues the switching-clock ticks. The tick rate drops to one third whenever the short-circuit flag is active.

The DAC that turns the ramp code into a voltage, the bandgap and the temperature sensor are outside the block. They appear only as flags and codes.

Top module: `softstart_seq`

## Requirements
- R1: While reset is held, and after it is released with enable low, the outputs are as follows: `ss_code` is 0, `reg_run`, `ref_wake_en`, `ramp_done` and `sw_tick` are 0, and `dis_en` is 1.
- R2: Once enable is high with no lockout and no thermal trip, `ref_wake_en` is high and `reg_run` is low for exactly WAKE_CYC clock cycles before `reg_run` rises.
- R3: While ramping, `ss_code` starts at 0 and rises by exactly 1 every STEP_CYC cycles until it reaches full scale, 2^CODE_W-1. The ramp phase lasts (2^CODE_W-1)*STEP_CYC+1 cycles, counted from `reg_run` rising to `ramp_done` rising.
- R4: Once full scale is reached, `ramp_done` is 1, `reg_run` stays 1 and `ss_code` holds at full scale.
- R5: When enable falls, `reg_run`, `ref_wake_en` and `ramp_done` go to 0 and `dis_en` goes to 1 in that same cycle, with no clock edge in between. `ss_code` reads 0 after the next clock edge.
- R6: While `uvlo_flag` is 1, the block behaves exactly as if enable were low, whatever the enable input does.
- R7: When `temp_hot` is 1, `reg_run`, `ref_wake_en` and `dis_en` are 0 in that same cycle, and `ss_code` is cleared. This takes priority over a simultaneous fall of enable.
- R8: After a thermal trip, the block stays off, with no discharge, until `temp_cool` is 1, even if enable is toggled. It then restarts with a full wake delay and a full ramp from code 0.
- R9: `ref_wake_en` stays 1 through the wake, ramp and run phases, and is 0 otherwise.
- R10: While `reg_run` is 1, `sw_tick` pulses once every SW_PERIOD cycles, or once every 3*SW_PERIOD cycles while `short_flag` is 1. While `reg_run` is 0 it never pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_in | input | 1 | Regulator enable request |
| uvlo_flag | input | 1 | Input supply below lockout level |
| temp_hot | input | 1 | Die at or above the shutdown temperature |
| temp_cool | input | 1 | Die at or below the restart temperature |
| short_flag | input | 1 | Feedback below the short-circuit level |
| ref_wake_en | output | 1 | Powers the internal reference |
| ss_code | output | CODE_W | Soft-start reference code |
| reg_run | output | 1 | Switching allowed (high-side switch may turn on) |
| dis_en | output | 1 | Output discharge path enable |
| ramp_done | output | 1 | Startup complete, reference at full scale |
| sw_tick | output | 1 | Switching clock tick |

## Verification
The thermal-trip path and the disable path can fire in the same cycle, and they disagree about the discharge output. The bench provokes this by raising `temp_hot` and lowering enable on the same falling edge while the regulator runs. It then expects `dis_en` to stay low, with the fault state winning. The bench also lets `temp_hot` and `temp_cool` be asserted together, and checks that the trip still takes effect.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAKE  = 3'd1,
    ST_RAMP  = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAULT = 3'd4
  } seq_state_t;

  // Number of cycles the ramp phase occupies, from first ramp cycle to done.
  function automatic int unsigned ramp_span(input int unsigned full_code,
                                            input int unsigned step_cyc);
    return full_code * step_cyc + 1;
  endfunction

  // Terminal count of the switching divider; slow mode stretches by three.
  function automatic int unsigned tick_last(input int unsigned period,
                                            input bit slow);
    return slow ? (3 * period - 1) : (period - 1);
  endfunction

endpackage

// File: rtl/seq_delay.sv
module seq_delay #(
  parameter int unsigned CYC = 75000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end

  AST_DELAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt == '0); // R2

endmodule

// File: rtl/ramp_gen.sv
module ramp_gen #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned STEP_CYC = 540
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  output logic [CODE_W-1:0] code,
  output logic              at_full
);
  localparam int unsigned PW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(STEP_CYC - 1);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  logic [PW-1:0] presc;

  assign at_full = (code == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      presc <= '0;
    end else if (!active) begin
      code  <= '0;
      presc <= '0;
    end else if (!at_full) begin
      if (presc == PLAST) begin
        presc <= '0;
        code  <= code + 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> (code == $past(code) || code == $past(code) + 1'b1)); // R3

  AST_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active) |-> code == '0); // R5

endmodule

// File: rtl/sw_tick_gen.sv
module sw_tick_gen
  import softstart_pkg::*;
#(
  parameter int unsigned PERIOD = 78
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic slow,
  output logic tick
);
  localparam int unsigned CW = $clog2(3 * PERIOD);
  localparam logic [CW-1:0] LAST_FAST = CW'(tick_last(PERIOD, 1'b0));
  localparam logic [CW-1:0] LAST_SLOW = CW'(tick_last(PERIOD, 1'b1));

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = slow ? LAST_SLOW : LAST_FAST;
  assign tick = run_en && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run_en)    cnt <= '0;
    else if (cnt >= last) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_en) |-> cnt == '0); // R10

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_SLOW); // R10

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int unsigned WAKE_CYC  = 75000,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned STEP_CYC  = 540,
  parameter int unsigned SW_PERIOD = 78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_in,
  input  logic              uvlo_flag,
  input  logic              temp_hot,
  input  logic              temp_cool,
  input  logic              short_flag,
  output logic              ref_wake_en,
  output logic [CODE_W-1:0] ss_code,
  output logic              reg_run,
  output logic              dis_en,
  output logic              ramp_done,
  output logic              sw_tick
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  seq_state_t state, state_nx;
  logic therm_lock;
  logic kill, trip, live;
  logic wake_done, at_full, ramp_active;

  // Named internal events
  assign kill = !enable_in || uvlo_flag;
  assign trip = temp_hot || (therm_lock && !temp_cool);
  assign live = !kill && !trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) therm_lock <= 1'b0;
    else        therm_lock <= trip;
  end

  always_comb begin
    state_nx = state;
    if (trip)      state_nx = ST_FAULT;
    else if (kill) state_nx = ST_OFF;
    else begin
      unique case (state)
        ST_OFF, ST_FAULT: state_nx = ST_WAKE;
        ST_WAKE:          state_nx = wake_done ? ST_RAMP : ST_WAKE;
        ST_RAMP:          state_nx = at_full ? ST_RUN : ST_RAMP;
        ST_RUN:           state_nx = ST_RUN;
        default:          state_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= state_nx;
  end

  assign ramp_active = live && (state == ST_RAMP || state == ST_RUN);

  seq_delay #(.CYC(WAKE_CYC)) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (live && state == ST_WAKE),
    .done (wake_done)
  );

  ramp_gen #(.CODE_W(CODE_W), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (ramp_active),
    .code   (ss_code),
    .at_full(at_full)
  );

  sw_tick_gen #(.PERIOD(SW_PERIOD)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run_en(reg_run),
    .slow  (short_flag),
    .tick  (sw_tick)
  );

  assign ref_wake_en = live && (state == ST_WAKE || state == ST_RAMP || state == ST_RUN);
  assign reg_run     = ramp_active;
  assign ramp_done   = live && (state == ST_RUN);
  assign dis_en      = !trip && (kill || state == ST_OFF);

  AST_WAKE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RAMP && $past(state) != ST_RAMP) |-> ($past(state) == ST_WAKE && $past(wake_done))); // R2

  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> ss_code == FULL); // R4

  AST_HOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(temp_hot) |-> state == ST_FAULT); // R7

  AST_THERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_lock && !temp_cool) |-> (!reg_run && !ref_wake_en && !dis_en)); // R8

  AST_UVLO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uvlo_flag) && !$past(temp_hot) && !$past(therm_lock) |-> state == ST_OFF); // R6

endmodule

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;
  localparam int W    = 10;
  localparam int CW   = 4;
  localparam int STEP = 3;
  localparam int P    = 4;
  localparam int FULL = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_in = 1'b0, uvlo_flag = 1'b0, temp_hot = 1'b0, temp_cool = 1'b1, short_flag = 1'b0;
  logic ref_wake_en, reg_run, dis_en, ramp_done, sw_tick;
  logic [CW-1:0] ss_code;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  softstart_seq #(.WAKE_CYC(W), .CODE_W(CW), .STEP_CYC(STEP), .SW_PERIOD(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable_in(enable_in), .uvlo_flag(uvlo_flag),
    .temp_hot(temp_hot), .temp_cool(temp_cool), .short_flag(short_flag),
    .ref_wake_en(ref_wake_en), .ss_code(ss_code), .reg_run(reg_run),
    .dis_en(dis_en), .ramp_done(ramp_done), .sw_tick(sw_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // [19] en [18] uvlo [17] hot [16] cool [15:8] wait [7:4] req [3] run [2] wake [1] dis [0] done
  localparam logic [19:0] TBL [0:12] = '{
    {4'b1001, 8'd80, 4'd4, 4'b1101},  // R4 full startup
    {4'b1010, 8'd2,  4'd7, 4'b0000},  // R7 thermal trip
    {4'b1000, 8'd80, 4'd8, 4'b0000},  // R8 lock without cool
    {4'b0000, 8'd5,  4'd8, 4'b0000},  // R8 disable while locked: no discharge
    {4'b1001, 8'd5,  4'd8, 4'b0100},  // R8 cool: restart in wake
    {4'b1001, 8'd80, 4'd8, 4'b1101},  // R8 full ramp again
    {4'b1101, 8'd1,  4'd6, 4'b0010},  // R6 lockout while running
    {4'b1101, 8'd40, 4'd6, 4'b0010},  // R6 held off
    {4'b1001, 8'd3,  4'd2, 4'b0100},  // R2 waking
    {4'b1001, 8'd15, 4'd3, 4'b1100},  // R3 mid ramp
    {4'b1001, 8'd80, 4'd4, 4'b1101},  // R4 done again
    {4'b0011, 8'd3,  4'd7, 4'b0000},  // R7 trip and disable together, hot with cool
    {4'b1001, 8'd60, 4'd8, 4'b1101}   // R8 cool clears lock at once
  };

  initial begin
    int wcnt, rcnt, bad_step, ticks, gap;
    logic [CW-1:0] prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 run", reg_run, 0); chk("R1 wake", ref_wake_en, 0);
    chk("R1 dis", dis_en, 1); chk("R1 code", ss_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code after release", ss_code, 0); chk("R1 dis after release", dis_en, 1);
    chk("R1 done", ramp_done, 0); chk("R1 tick", sw_tick, 0);

    // R2 / R3 / R9: measure wake and ramp phases
    enable_in = 1'b1;
    wcnt = 0; rcnt = 0; bad_step = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ramp_done) break;
      if (ref_wake_en && !reg_run) wcnt++;
      if (reg_run) begin
        if (!ref_wake_en) bad_step++;                // R9
        if (int'(ss_code) != rcnt / STEP) bad_step++; // R3
        rcnt++;
      end
    end
    chk("R2 wake cycles", wcnt, W);
    chk("R3 ramp cycles", rcnt, FULL * STEP + 1);
    chk("R3 code steps", bad_step, 0);
    chk("R4 code full", ss_code, FULL);
    repeat (20) @(negedge clk);
    chk("R4 hold code", ss_code, FULL); chk("R4 run", reg_run, 1);
    chk("R9 wake in run", ref_wake_en, 1);

    // R10 tick spacing
    while (!sw_tick) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sw_tick);
    chk("R10 normal period", gap, P);
    short_flag = 1'b1;
    @(negedge clk); while (!sw_tick) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sw_tick);
    chk("R10 slow period", gap, 3 * P);
    short_flag = 1'b0;

    // R5 immediate disable
    enable_in = 1'b0;
    #1;
    chk("R5 run same cycle", reg_run, 0); chk("R5 dis same cycle", dis_en, 1);
    chk("R5 wake same cycle", ref_wake_en, 0); chk("R5 done same cycle", ramp_done, 0);
    @(negedge clk);
    chk("R5 code cleared", ss_code, 0);
    ticks = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); ticks += sw_tick; end
    chk("R10 no tick when off", ticks, 0);

    // Vector table walk
    for (int k = 0; k < 13; k++) begin
      enable_in = TBL[k][19]; uvlo_flag = TBL[k][18];
      temp_hot  = TBL[k][17]; temp_cool = TBL[k][16];
      repeat (int'(TBL[k][15:8])) @(negedge clk);
      chk($sformatf("R%0d row%0d run", TBL[k][7:4], k), reg_run, TBL[k][3]);
      chk($sformatf("R%0d row%0d wake", TBL[k][7:4], k), ref_wake_en, TBL[k][2]);
      chk($sformatf("R%0d row%0d dis", TBL[k][7:4], k), dis_en, TBL[k][1]);
      chk($sformatf("R%0d row%0d done", TBL[k][7:4], k), ramp_done, TBL[k][0]);
    end

    // R7 same-cycle thermal cut from run, code cleared
    temp_hot = 1'b1;
    #1;
    chk("R7 run same cycle", reg_run, 0); chk("R7 no discharge", dis_en, 0);
    @(negedge clk);
    chk("R7 code cleared", ss_code, 0);
    temp_hot = 1'b0; temp_cool = 1'b1;
    prev = '0;
    repeat (W + 2) @(negedge clk);
    chk("R8 restart from zero", ss_code, prev);

    finish_run();
  end
endmodule